// File: doc/BRIEF.md
# Split-Half Integer Multiplier

This unit multiplies two 32-bit integer operands and returns one 32-bit half of the 64-bit product. A 2-bit operation select chooses between the low half and three high-half variants. The high-half variants differ in how each operand's sign is read: both signed, signed times unsigned, or both unsigned. The low half is the same whichever way the operands are read. An execution stage fires a one-cycle `inValid` together with the operands and the select. It then waits for the one-cycle `outDone` strobe, when `outResult` holds the answer.

The arithmetic widens each operand by one bit, using sign extension or zero extension as the operation requires. It then forms one signed product of the widened operands and picks the requested half from it. After an accepted request the unit stays busy for `LATENCY` cycles, so the same interface fits a one-cycle unit or a deeper unit. To get the full signed 64-bit product, issue the signed high-half request and then the low-half request on the same operands.

Top module: `mul_hl_unit`

## Requirements
- R1: With `opSel` = 2'b00, the result is bits 31:0 of the product, and this value is the same whether the operands are read as signed or as unsigned.
- R2: With `opSel` = 2'b01, both operands are read as two's-complement, and the result is product bits 63:32.
- R3: With `opSel` = 2'b11, both operands are read as unsigned, and the result is product bits 63:32.
- R4: With `opSel` = 2'b10, `opA` is read as signed and `opB` as unsigned, and the result is product bits 63:32.
- R5: After an accepted `inValid`, `outDone` is high for exactly one cycle, `LATENCY` cycles later (default 2).
- R6: `busy` is high from the cycle after acceptance until the result is produced, and is never high in the same cycle as `outDone`.
- R7: `outResult` changes only when `outDone` is asserted, and it holds its value until the next accepted request completes.
- R8: An `inValid` that arrives while `busy` is high is ignored: that request produces no result and does not change the result of the request in progress.
- R9: While reset is held and after it is released, `busy`, `outDone` and `outResult` are all zero.
- R10: A 2'b01 result followed by a 2'b00 result on the same operands, concatenated high over low, equals the full signed 64-bit product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | One-cycle request strobe |
| opSel | input | 2 | Operation select (see R1 to R4) |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| busy | output | 1 | A request is in progress |
| outDone | output | 1 | One-cycle result-valid strobe |
| outResult | output | 32 | Selected half of the product |

## Verification
On every cycle, the assertions check the handshake timing: the done strobe lasts one cycle and follows a busy cycle, busy and done never overlap, busy continues until done, and the result holds between done strobes. The values of the product halves are checked only by the bench's scenarios. These compare each signedness mode against a 64-bit reference, using operands near the sign boundaries. The bench scenarios also cover ignoring a request that arrives while busy, the exact latency, and building the full product from two requests.

// File: rtl/mul_hl_pkg.sv
package mul_hl_pkg;
  typedef enum logic [1:0] {
    OP_LOW  = 2'b00,
    OP_HISS = 2'b01,
    OP_HISU = 2'b10,
    OP_HIUU = 2'b11
  } mulOp_e;

  typedef struct packed {
    logic loadOps;
    logic storeResult;
  } mulStrobes_t;
endpackage

// File: rtl/mul_hl_ctrl.sv
module mul_hl_ctrl
  import mul_hl_pkg::*;
#(
  parameter int LATENCY = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output logic        busy,
  output logic        outDone,
  output mulStrobes_t strobes
);
  localparam int CW = (LATENCY > 1) ? $clog2(LATENCY) : 1;

  logic [CW-1:0] remaining;

  always_comb begin
    strobes.loadOps     = inValid && !busy;
    strobes.storeResult = busy && (remaining == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      outDone   <= 1'b0;
      remaining <= '0;
    end else begin
      outDone <= strobes.storeResult;
      if (strobes.loadOps) begin
        busy      <= 1'b1;
        remaining <= CW'(LATENCY - 1);
      end else if (strobes.storeResult) begin
        busy <= 1'b0;
      end else if (busy) begin
        remaining <= remaining - 1'b1;
      end
    end
  end
endmodule

// File: rtl/mul_hl_dpath.sv
module mul_hl_dpath
  import mul_hl_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  mulStrobes_t     strobes,
  input  logic [1:0]      opSel,
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  output logic [XLEN-1:0] outResult
);
  localparam int EW = XLEN + 1;
  localparam int PW = 2 * EW;

  logic signed [EW-1:0] aExt, bExt;
  logic                 wantLow;
  logic signed [PW-1:0] product;
  logic                 aSigned, bSigned;

  always_comb begin
    aSigned = (opSel != OP_HIUU);
    bSigned = (opSel == OP_LOW) || (opSel == OP_HISS);
    product = aExt * bExt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aExt      <= '0;
      bExt      <= '0;
      wantLow   <= 1'b1;
      outResult <= '0;
    end else begin
      if (strobes.loadOps) begin
        aExt    <= {aSigned & opA[XLEN-1], opA};
        bExt    <= {bSigned & opB[XLEN-1], opB};
        wantLow <= (opSel == OP_LOW);
      end
      if (strobes.storeResult) begin
        outResult <= wantLow ? product[XLEN-1:0] : product[2*XLEN-1:XLEN];
      end
    end
  end
endmodule

// File: rtl/mul_hl_unit.sv
module mul_hl_unit
  import mul_hl_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int LATENCY = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [1:0]      opSel,
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  output logic            busy,
  output logic            outDone,
  output logic [XLEN-1:0] outResult
);
  mulStrobes_t strobes;

  mul_hl_ctrl #(.LATENCY(LATENCY)) ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .busy(busy), .outDone(outDone), .strobes(strobes)
  );

  mul_hl_dpath #(.XLEN(XLEN)) dpath_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .opSel(opSel),
    .opA(opA), .opB(opB), .outResult(outResult)
  );
endmodule

// File: rtl/mul_hl_checker.sv
module mul_hl_checker #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            busy,
  input logic            outDone,
  input logic [XLEN-1:0] outResult
);
  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    outDone |=> !outDone);

  assert_done_after_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    outDone |-> $past(busy));

  assert_busy_done_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && outDone));

  assert_busy_until_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (busy || outDone));

  assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !outDone |-> $stable(outResult));
endmodule

bind mul_hl_unit mul_hl_checker #(.XLEN(XLEN)) chk_i (
  .clk(clk), .rstN(rstN), .busy(busy), .outDone(outDone), .outResult(outResult)
);

// File: tb/mul_hl_unit_tb_top.sv
module mul_hl_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  opSel = 2'b00;
  logic [31:0] opA = '0, opB = '0;
  logic        busy, outDone;
  logic [31:0] outResult;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mul_hl_unit #(.XLEN(32), .LATENCY(LAT)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .opA(opA), .opB(opB), .busy(busy), .outDone(outDone), .outResult(outResult)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] refHalf(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    logic [63:0] sa, ua, sb, ub, p;
    sa = {{32{a[31]}}, a}; ua = {32'b0, a};
    sb = {{32{b[31]}}, b}; ub = {32'b0, b};
    case (op)
      2'b00: p = ua * ub;
      2'b01: p = sa * sb;
      2'b10: p = sa * ub;
      default: p = ua * ub;
    endcase
    return (op == 2'b00) ? p[31:0] : p[63:32];
  endfunction

  // Issue one request and return its result; checks latency (R5) and busy (R6).
  task automatic issue(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                       output logic [31:0] res);
    int n;
    @(negedge clk);
    inValid = 1'b1; opSel = op; opA = a; opB = b;
    @(negedge clk);
    inValid = 1'b0;
    check("R6 busy after accept", {63'b0, busy}, 64'd1);
    n = 0;
    while (!outDone) begin
      @(negedge clk);
      n++;
    end
    check("R5 latency", 64'(n), 64'(LAT));
    res = outResult;
    @(negedge clk);
    check("R5 done single cycle", {63'b0, outDone}, 64'd0);
  endtask

  task automatic testReset();
    check("R9 busy at reset", {63'b0, busy}, 64'd0);
    check("R9 done at reset", {63'b0, outDone}, 64'd0);
    check("R9 result at reset", {32'b0, outResult}, 64'd0);
  endtask

  task automatic testOp(input string req, input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r;
    issue(op, a, b, r);
    check(req, {32'b0, r}, {32'b0, refHalf(op, a, b)});
  endtask

  task automatic testLowSignAgnostic();
    logic [31:0] r;
    issue(2'b00, 32'hFFFF_FFFE, 32'h0000_0003, r);
    check("R1 low of -2*3", {32'b0, r}, {32'b0, 32'hFFFF_FFFA});
  endtask

  task automatic testIgnoreBusy();
    logic [31:0] r;
    int n;
    @(negedge clk);
    inValid = 1'b1; opSel = 2'b01; opA = 32'h0001_0000; opB = 32'h0003_0000;
    @(negedge clk);
    opSel = 2'b11; opA = 32'hFFFF_FFFF; opB = 32'hFFFF_FFFF;
    @(negedge clk);
    inValid = 1'b0;
    n = 1;
    while (!outDone) begin
      @(negedge clk);
      n++;
    end
    r = outResult;
    check("R8 busy request ignored", {32'b0, r}, 64'h3);
    check("R8 latency kept", 64'(n), 64'(LAT));
    repeat (4) begin
      @(negedge clk);
      check("R8 no second done", {62'b0, busy, outDone}, 64'd0);
    end
  endtask

  task automatic testHold();
    logic [31:0] r0;
    r0 = outResult;
    opA = 32'h1234_5678; opB = 32'h9ABC_DEF0; opSel = 2'b10;
    repeat (3) @(negedge clk);
    check("R7 result held while idle", {32'b0, outResult}, {32'b0, r0});
  endtask

  task automatic testFullProduct(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] hi, lo;
    logic [63:0] full;
    issue(2'b01, a, b, hi);
    issue(2'b00, a, b, lo);
    full = {{32{a[31]}}, a} * {{32{b[31]}}, b};
    check("R10 full signed product", {hi, lo}, full);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (2) @(negedge clk);
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testOp("R1 low small", 2'b00, 32'd46, 32'd10);
    testLowSignAgnostic();
    testOp("R2 high ss neg*pos", 2'b01, 32'h8000_0000, 32'h0000_0003);
    testOp("R2 high ss neg*neg", 2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    testOp("R2 high ss min*min", 2'b01, 32'h8000_0000, 32'h8000_0000);
    testOp("R3 high uu max*max", 2'b11, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    testOp("R3 high uu mixed", 2'b11, 32'h8000_0001, 32'h7FFF_FFFF);
    testOp("R4 high su neg*big", 2'b10, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    testOp("R4 high su pos*big", 2'b10, 32'h7FFF_FFFF, 32'h8000_0000);
    testOp("R4 high su min*max", 2'b10, 32'h8000_0000, 32'hFFFF_FFFF);
    testIgnoreBusy();
    testHold();
    testFullProduct(32'hDEAD_BEEF, 32'h0123_4567);
    testFullProduct(32'h8000_0000, 32'hFFFF_FFFF);
    summary();
  end
endmodule